// File: doc/BRIEF.md
# Cache Way Replacement Selector

This unit decides which way of a set-associative cache is overwritten when a lookup misses. The cache controller presents the set index together with the valid bits of that set's ways. On a miss strobe the selector returns the way to refill in the same cycle. Lookups that hit report the way that matched, so that recency can be tracked.

The replacement rule is fixed at build time by a parameter, and the unit keeps only the state that rule needs:
- **Random:** one counter shared by every set.
- **FIFO:** one round-robin pointer per set.
- **LRU:** a full least-to-most-recent ordering per set, which shrinks to one bit per set for two-way caches.

Whatever the rule, an empty way in the set is filled before any occupied way is displaced. The unit does no tag matching and holds no data.

Top module: `victim_select`

## Requirements
- R1: On a miss where at least one of the set's ways has its valid bit at 0, the victim is the lowest-numbered such way, whatever the policy.
- R2: Random policy: a single counter shared by all sets holds 0 after reset and steps by one (wrapping from NUM_WAYS-1 to 0) on every clock edge after reset. On a miss with all ways valid, the victim is its current value.
- R3: FIFO policy: each set owns a pointer that steps by one modulo NUM_WAYS on every miss in that set, including misses resolved by R1. Hits and misses in other sets leave it unchanged. On a miss with all ways valid, the victim is the pointer's value.
- R4: LRU policy: on a miss with all ways valid, the victim is the least recently touched way of the set. A hit makes the hit way the most recent and keeps the relative order of the others.
- R5: LRU policy: the way returned on a miss (the refilled way) becomes the most recent of its set, exactly as a hit would.
- R6: LRU policy with NUM_WAYS = 2 keeps one bit per set and behaves as R4 and R5 describe.
- R7: With NUM_WAYS = 1 the victim is always way 0.
- R8: The victim is a combinational function of the current inputs and the state. Any state change caused by a hit or a miss first shows on the cycle after the strobe.
- R9: After reset every FIFO pointer and the random counter are 0. Each set's LRU order is way 0 least recent up to way NUM_WAYS-1 most recent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | SET_W | Set addressed by the current lookup |
| hit_stb | input | 1 | Lookup hit; ignored when miss_stb is high |
| hit_way | input | WAY_W | Way that matched on a hit |
| miss_stb | input | 1 | Lookup missed; victim_way is used for refill |
| way_valid | input | NUM_WAYS | Valid bit of each way of the addressed set |
| victim_way | output | WAY_W | Way chosen for replacement |

## Verification
The bench builds five instances side by side, each with four sets:
- a four-way LRU instance;
- a four-way FIFO instance;
- a four-way random instance;
- a two-way LRU instance, which reaches the one-bit-per-set variant;
- a direct-mapped instance.

With four ways, all sixteen valid-bit patterns can be swept for every set. The four-entry orderings are also small enough to be walked through many permutations by a long pseudo-random hit and miss sequence. The expected victims come from a list-based recency model, a per-set pointer model and a cycle count kept in the bench.

// File: rtl/vsel_pkg.sv
package vsel_pkg;

    typedef enum logic [1:0] {
        POL_RANDOM = 2'd0,
        POL_FIFO   = 2'd1,
        POL_LRU    = 2'd2
    } policy_e;

endpackage

// File: rtl/vsel_invalid_pick.sv
module vsel_invalid_pick #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0] way_valid,
    output logic                any_free,
    output logic [WAY_W-1:0]    free_way
);

    // Scan from the top down so that the lowest empty way wins.
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/vsel_rand_ctr.sv
module vsel_rand_ctr #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WAY_W-1:0] cnt
);

    typedef struct packed {
        logic [WAY_W-1:0] cnt;
    } rand_st_t;

    rand_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == WAY_W'(NUM_WAYS - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    // R2: the shared counter never leaves 0..NUM_WAYS-1
    a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= WAY_W'(NUM_WAYS - 1));

    // R2: the counter moves on every cycle
    a_r2_free_running: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |=> st_q.cnt != $past(st_q.cnt));

endmodule

// File: rtl/vsel_fifo_ctrs.sv
module vsel_fifo_ctrs #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             miss_stb,
    output logic [WAY_W-1:0] oldest
);

    typedef struct packed {
        logic [NUM_SETS-1:0][WAY_W-1:0] ptr;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (miss_stb) begin
            if (st_q.ptr[set_idx] == WAY_W'(NUM_WAYS - 1)) begin
                st_d.ptr[set_idx] = '0;
            end else begin
                st_d.ptr[set_idx] = st_q.ptr[set_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign oldest = st_q.ptr[set_idx];

    // R3: without a miss no pointer moves
    a_r3_hold_on_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_stb |=> st_q.ptr == $past(st_q.ptr));

    // R3: a miss always moves the pointer of the addressed set
    a_r3_step_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb |=> st_q.ptr[$past(set_idx)] != $past(st_q.ptr[set_idx]));

endmodule

// File: rtl/vsel_lru_order.sv
module vsel_lru_order #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_stb,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss_stb,
    input  logic [WAY_W-1:0] fill_way,
    output logic [WAY_W-1:0] lru_way
);

    logic             touch;
    logic [WAY_W-1:0] touch_way;

    always_comb begin
        touch     = miss_stb || hit_stb;
        touch_way = miss_stb ? fill_way : hit_way;
    end

    generate
        if (NUM_WAYS == 2) begin : g_bit
            // One bit per set naming the least recent way.
            typedef struct packed {
                logic [NUM_SETS-1:0] lru;
            } bit_st_t;

            bit_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (touch) begin
                    st_d.lru[set_idx] = ~touch_way[0];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign lru_way = WAY_W'(st_q.lru[set_idx]);

            // R6: after a hit the other way is the least recent one
            a_r6_hit_flips: assert property (@(posedge clk) disable iff (!rst_n)
                hit_stb && !miss_stb |=> st_q.lru[$past(set_idx)] != $past(hit_way[0]));

            // R6: the refilled way is not the next victim of its set
            a_r6_fill_flips: assert property (@(posedge clk) disable iff (!rst_n)
                miss_stb |=> st_q.lru[$past(set_idx)] != $past(fill_way[0]));
        end else begin : g_age
            // Per way rank: 0 = least recent, NUM_WAYS-1 = most recent.
            typedef struct packed {
                logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] age;
            } age_st_t;

            age_st_t             st_d, st_q;
            logic [WAY_W-1:0]    rank;
            logic [NUM_WAYS-1:0] zero_mask;

            always_comb begin
                st_d = st_q;
                rank = st_q.age[set_idx][touch_way];
                if (touch) begin
                    for (int w = 0; w < NUM_WAYS; w++) begin
                        if (st_q.age[set_idx][w] > rank) begin
                            st_d.age[set_idx][w] = st_q.age[set_idx][w] - 1'b1;
                        end
                    end
                    st_d.age[set_idx][touch_way] = WAY_W'(NUM_WAYS - 1);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < NUM_SETS; s++) begin
                        for (int w = 0; w < NUM_WAYS; w++) begin
                            st_q.age[s][w] <= WAY_W'(w);
                        end
                    end
                end else begin
                    st_q <= st_d;
                end
            end

            always_comb begin
                lru_way = '0;
                for (int w = 0; w < NUM_WAYS; w++) begin
                    zero_mask[w] = (st_q.age[set_idx][w] == '0);
                    if (zero_mask[w]) begin
                        lru_way = WAY_W'(w);
                    end
                end
            end

            // R4: the ranks of the addressed set always hold exactly one least recent way
            a_r4_single_lru: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(zero_mask) == 1);

            // R4: a hit way becomes the most recent of its set
            a_r4_hit_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
                hit_stb && !miss_stb |=> st_q.age[$past(set_idx)][$past(hit_way)] == WAY_W'(NUM_WAYS - 1));

            // R5: a refilled way becomes the most recent of its set
            a_r5_fill_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
                miss_stb |=> st_q.age[$past(set_idx)][$past(fill_way)] == WAY_W'(NUM_WAYS - 1));
        end
    endgenerate

endmodule

// File: rtl/victim_select.sv
module victim_select #(
    parameter int                NUM_SETS = 16,
    parameter int                NUM_WAYS = 4,
    parameter vsel_pkg::policy_e POLICY   = vsel_pkg::POL_LRU,
    localparam int               SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int               WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    set_idx,
    input  logic                hit_stb,
    input  logic [WAY_W-1:0]    hit_way,
    input  logic                miss_stb,
    input  logic [NUM_WAYS-1:0] way_valid,
    output logic [WAY_W-1:0]    victim_way
);

    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] policy_way;

    vsel_invalid_pick #(
        .NUM_WAYS (NUM_WAYS),
        .WAY_W    (WAY_W)
    ) u_free (
        .way_valid (way_valid),
        .any_free  (any_free),
        .free_way  (free_way)
    );

    generate
        if (NUM_WAYS == 1) begin : g_direct
            assign policy_way = '0;
        end else if (POLICY == vsel_pkg::POL_RANDOM) begin : g_random
            vsel_rand_ctr #(
                .NUM_WAYS (NUM_WAYS),
                .WAY_W    (WAY_W)
            ) u_rand (
                .clk   (clk),
                .rst_n (rst_n),
                .cnt   (policy_way)
            );
        end else if (POLICY == vsel_pkg::POL_FIFO) begin : g_fifo
            vsel_fifo_ctrs #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS),
                .SET_W    (SET_W),
                .WAY_W    (WAY_W)
            ) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_idx  (set_idx),
                .miss_stb (miss_stb),
                .oldest   (policy_way)
            );
        end else begin : g_lru
            vsel_lru_order #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS),
                .SET_W    (SET_W),
                .WAY_W    (WAY_W)
            ) u_lru (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_idx  (set_idx),
                .hit_stb  (hit_stb),
                .hit_way  (hit_way),
                .miss_stb (miss_stb),
                .fill_way (victim_way),
                .lru_way  (policy_way)
            );
        end
    endgenerate

    always_comb begin
        victim_way = any_free ? free_way : policy_way;
    end

    // R1: an empty way is never passed over for an occupied one
    a_r1_free_chosen: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb && !(&way_valid) |-> !way_valid[victim_way]);

    // R1: every way below the chosen empty way is occupied
    a_r1_lowest_free: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stb && !(&way_valid) |->
            ((way_valid & ((NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1)))
             == ((NUM_WAYS'(1) << victim_way) - NUM_WAYS'(1))));

    // R7: victim index stays inside the way range
    a_r7_way_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(victim_way) < NUM_WAYS);

endmodule

// File: tb/victim_select_tb.sv
module victim_select_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] set_idx;
    logic       hit_stb;
    logic [1:0] hit_way;
    logic       miss_stb;
    logic [3:0] way_valid;

    logic [1:0] v_lru4, v_fifo, v_rand;
    logic [0:0] v_lru2, v_dm;

    int vectors    = 0;
    int miscompares = 0;
    bit finished   = 0;

    int ord4 [4][4];
    int ord2 [4][2];
    int fptr [4];
    int rcnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    victim_select #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::POL_LRU)) dut_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_stb(hit_stb), .hit_way(hit_way),
        .miss_stb(miss_stb), .way_valid(way_valid), .victim_way(v_lru4));

    victim_select #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::POL_FIFO)) dut_fifo_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_stb(hit_stb), .hit_way(hit_way),
        .miss_stb(miss_stb), .way_valid(way_valid), .victim_way(v_fifo));

    victim_select #(.NUM_SETS(4), .NUM_WAYS(4), .POLICY(vsel_pkg::POL_RANDOM)) dut_rand_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_stb(hit_stb), .hit_way(hit_way),
        .miss_stb(miss_stb), .way_valid(way_valid), .victim_way(v_rand));

    victim_select #(.NUM_SETS(4), .NUM_WAYS(2), .POLICY(vsel_pkg::POL_LRU)) dut_lru2_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_stb(hit_stb), .hit_way(hit_way[0]),
        .miss_stb(miss_stb), .way_valid(way_valid[1:0]), .victim_way(v_lru2));

    victim_select #(.NUM_SETS(4), .NUM_WAYS(1), .POLICY(vsel_pkg::POL_LRU)) dut_dm_i (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .hit_stb(hit_stb), .hit_way(1'b0),
        .miss_stb(miss_stb), .way_valid(way_valid[0:0]), .victim_way(v_dm));

    function automatic int first_free(input logic [3:0] v, input int n);
        for (int w = 0; w < n; w++) begin
            if (!v[w]) return w;
        end
        return -1;
    endfunction

    task automatic touch4(input int s, input int t);
        int p = 0;
        for (int k = 0; k < 4; k++) if (ord4[s][k] == t) p = k;
        for (int k = p; k < 3; k++) ord4[s][k] = ord4[s][k + 1];
        ord4[s][3] = t;
    endtask

    task automatic touch2(input int s, input int t);
        if (ord2[s][0] == t) begin
            ord2[s][0] = ord2[s][1];
            ord2[s][1] = t;
        end
    endtask

    task automatic check(input string name, input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s %s: victim %0d expected %0d at %0t", tag, name, got, exp, $time);
        end
    endtask

    // Called just after a falling edge; drives, checks before the next rising edge,
    // then advances the reference models and returns at the following falling edge.
    task automatic step(input int s, input bit h, input int hw, input bit m,
                        input logic [3:0] v, input string tag_over);
        int f4, f2, e4, ef, er, e2;
        string t4, tf, tr, t2, td;
        set_idx   = 2'(s);
        hit_stb   = h;
        hit_way   = 2'(hw);
        miss_stb  = m;
        way_valid = v;
        #1;
        f4 = first_free(v, 4);
        f2 = first_free(v, 2);
        e4 = (f4 >= 0) ? f4 : ord4[s][0];
        ef = (f4 >= 0) ? f4 : fptr[s];
        er = (f4 >= 0) ? f4 : rcnt;
        e2 = (f2 >= 0) ? f2 : ord2[s][0];
        if (m) begin
            t4 = (f4 >= 0) ? "R1" : "R4,R5";
            tf = (f4 >= 0) ? "R1" : "R3";
            tr = (f4 >= 0) ? "R1" : "R2";
            t2 = (f2 >= 0) ? "R1" : "R6";
            td = "R7";
            if (tag_over != "") begin
                t4 = tag_over; tf = tag_over; tr = tag_over; t2 = tag_over; td = tag_over;
            end
            check("lru4", t4, int'(v_lru4), e4);
            check("fifo", tf, int'(v_fifo), ef);
            check("rand", tr, int'(v_rand), er);
            check("lru2", t2, int'(v_lru2), e2);
            check("direct", td, int'(v_dm), 0);
        end
        @(posedge clk);
        rcnt = (rcnt + 1) % 4;
        if (m) begin
            fptr[s] = (fptr[s] + 1) % 4;
            touch4(s, e4);
            touch2(s, e2);
        end else if (h) begin
            touch4(s, hw);
            touch2(s, hw % 2);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run state hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        rst_n = 1'b0; set_idx = '0; hit_stb = 1'b0; hit_way = '0;
        miss_stb = 1'b0; way_valid = '0;
        for (int s = 0; s < 4; s++) begin
            fptr[s] = 0;
            for (int k = 0; k < 4; k++) ord4[s][k] = k;
            for (int k = 0; k < 2; k++) ord2[s][k] = k;
        end
        rcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state seen through the first all-valid miss in every set
        for (int s = 0; s < 4; s++) step(s, 0, 0, 1, 4'hF, "R9");

        // R8: back-to-back misses in one set; the update lands on the edge between them
        step(0, 0, 0, 1, 4'hF, "R8");
        step(0, 0, 0, 1, 4'hF, "R8");

        // R1: every valid pattern in every set
        for (int s = 0; s < 4; s++)
            for (int v = 0; v < 16; v++) step(s, 0, 0, 1, 4'(v), "");

        // R4: hit-only walk that reverses the order of set 2, then a miss reads it
        for (int w = 3; w >= 0; w--) step(2, 1, w, 0, 4'hF, "");
        step(2, 0, 0, 1, 4'hF, "R4");

        // Mixed pseudo-random traffic covering R2 R3 R4 R5 R6 R7
        for (int i = 0; i < 3000; i++) begin
            int kind, s, w;
            logic [3:0] v;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            kind = int'(lcg[31:28]);
            s    = int'(lcg[21:20]);
            w    = int'(lcg[19:18]);
            v    = (lcg[27:25] == 3'd0) ? lcg[15:12] : 4'hF;
            if (kind < 8)       step(s, 1, w, 0, 4'hF, "");
            else if (kind < 14) step(s, 0, 0, 1, v, "");
            else                step(s, 0, 0, 0, 4'hF, "");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule